// File: doc/BRIEF.md
# Gated Input Event Timestamper

This block watches one asynchronous digital input and writes events into a small queue. Each queue entry carries the value of a free-running wall-clock counter and two bits of data. Edges are recorded only while a gate is open, and the gate opens and closes at wall-clock times chosen by the controller. The controller can also ask for a one-shot sample of the input level at a chosen time. A processor-side read port removes entries one at a time.

The gate command and the sample request each have one pending slot. A command waits in its slot until the wall clock reaches its time, so any event count read back is only complete once the wall clock has passed the close time. If an event arrives while the queue is full, that event is lost and a sticky overflow flag is set. The flag is not raised as an interrupt. It is returned with the next read response, and that read clears it.

Top module: `evt_stamper`

## Requirements
- R1: `now_o` is 0 in the first cycle after reset is released and increases by one on every clock.
- R2: After reset the queue is empty, the gate is closed and the overflow flag is clear. No response is presented until a read is issued.
- R3: While the gate is open, its mode selects which edges are recorded: 01 records rising edges, 10 records falling edges and 11 records both. Each edge entry has data bit1=0 and data bit0 equal to the new level. An input change first sampled at the clock edge that ends the cycle with `now_o`=N is stamped N+2, because of the two-flop synchronizer.
- R4: A gate command takes effect in the first cycle in which `now_o` is greater than or equal to its time. Mode 00 closes the gate. An edge stamped before the open time is not recorded. An edge stamped at or after the close time is not recorded.
- R5: A sample request records one entry in the first cycle in which `now_o` is at or past its time, even when the gate is closed. The entry has data bit1=1 and data bit0 equal to the synchronized level. If an edge falls in the same cycle, only the sample entry is written.
- R6: A read request pulse produces `rsp_valid_o` in the next cycle. When the queue is not empty, the response carries the oldest entry, which is removed and `rsp_empty_o`=0. Entries come out in arrival order.
- R7: A read of an empty queue returns `rsp_empty_o`=1. `rsp_gate_o` shows whether the gate is open in the cycle of the request.
- R8: A push attempted while the queue holds DEPTH entries is dropped and sets the overflow flag. The entries already queued are kept.
- R9: The overflow flag is returned on `rsp_ovf_o` by the next read response and is cleared by that read. Later reads return 0 until a new overflow occurs.
- R10: A new gate command or sample request replaces one of the same kind that is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | 1 | Asynchronous input being watched |
| gate_set_i | input | 1 | Pulse that loads a gate command |
| gate_mode_i | input | 2 | Gate mode: 00 closed, 01 rising, 10 falling, 11 both |
| gate_time_i | input | TS_W | Wall-clock time of the gate command |
| smp_set_i | input | 1 | Pulse that loads a sample request |
| smp_time_i | input | TS_W | Wall-clock time of the sample |
| rd_req_i | input | 1 | Read request pulse |
| rsp_valid_o | output | 1 | Response valid, one cycle after a request |
| rsp_empty_o | output | 1 | No entry was pending |
| rsp_ovf_o | output | 1 | An overflow occurred since the previous read |
| rsp_gate_o | output | 1 | Gate was open at the time of the request |
| rsp_ts_o | output | TS_W | Timestamp of the entry |
| rsp_data_o | output | 2 | bit1 sample/edge, bit0 level |
| now_o | output | TS_W | Wall-clock counter |

## Verification
A table drives single rising and falling transitions under each of the four gate modes. This shows that the mode decodes to the correct edge polarity and that the stamp lands exactly two cycles after the input change. Directed patterns place back-to-back edges one cycle before and exactly at the open time and the close time. These tell an inclusive window boundary from an off-by-one one. Further cases cover a sample coinciding with an edge, a sample request replaced by a later one, and a burst of five edges into a four-entry queue. Together they separate sample priority, slot replacement, the kept-oldest overflow behaviour and the clear-on-read flag.

// File: rtl/ets_pkg.sv
package ets_pkg;
  localparam logic [1:0] GM_OFF  = 2'b00;
  localparam logic [1:0] GM_RISE = 2'b01;
  localparam logic [1:0] GM_FALL = 2'b10;
  localparam logic [1:0] GM_BOTH = 2'b11;
  localparam int unsigned DATA_W = 2;
  localparam int unsigned KIND_BIT = 1;
  localparam int unsigned LVL_BIT = 0;
endpackage

// File: rtl/ets_edge_det.sv
module ets_edge_det #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], sig_i};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign lvl_o  = sync_q[SYNC-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/ets_timed_slot.sv
// Single pending command that fires once the wall clock reaches its time.
module ets_timed_slot #(
  parameter int unsigned TS_W = 32,
  parameter int unsigned PW   = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [TS_W-1:0] time_i,
  input  logic [PW-1:0]   pay_i,
  input  logic [TS_W-1:0] now_i,
  output logic            fire_o,
  output logic [PW-1:0]   pay_o
);
  logic            pend_q;
  logic [TS_W-1:0] time_q;
  logic [PW-1:0]   pay_q;

  assign fire_o = pend_q && (now_i >= time_q);
  assign pay_o  = pay_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      time_q <= '0;
      pay_q  <= '0;
    end else if (set_i) begin
      pend_q <= 1'b1;
      time_q <= time_i;
      pay_q  <= pay_i;
    end else if (fire_o) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ets_fifo.sv
module ets_fifo #(
  parameter int unsigned W     = 34,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic [CW-1:0] fill_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] fill_q;
  logic          full, push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (fill_q == CW'(DEPTH));
  assign empty_o = (fill_q == '0);
  assign push_ok = push_i & ~full;
  assign pop_ok  = pop_i & ~empty_o;
  assign ovf_o   = push_i & full;   // full judged before a same-cycle pop
  assign head_o  = mem_q[rd_q];
  assign fill_o  = fill_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      if (push_ok && !pop_ok)      fill_q <= fill_q + 1'b1;
      else if (!push_ok && pop_ok) fill_q <= fill_q - 1'b1;
    end
  end
endmodule

// File: rtl/evt_stamper.sv
module evt_stamper
  import ets_pkg::*;
#(
  parameter int unsigned TS_W  = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned SYNC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sig_i,
  input  logic              gate_set_i,
  input  logic [1:0]        gate_mode_i,
  input  logic [TS_W-1:0]   gate_time_i,
  input  logic              smp_set_i,
  input  logic [TS_W-1:0]   smp_time_i,
  input  logic              rd_req_i,
  output logic              rsp_valid_o,
  output logic              rsp_empty_o,
  output logic              rsp_ovf_o,
  output logic              rsp_gate_o,
  output logic [TS_W-1:0]   rsp_ts_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [TS_W-1:0]   now_o
);
  localparam int unsigned EW = TS_W + DATA_W;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [TS_W-1:0] now_q;
  logic            lvl, rise, fall;
  logic            g_fire, s_fire, s_pay;
  logic [1:0]      g_pay, mode_q, mode_eff;
  logic            hit, push, fifo_ovf, empty, ovf_q;
  logic [EW-1:0]   wentry, head;
  logic [CW-1:0]   fill_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else         now_q <= now_q + 1'b1;
  end
  assign now_o = now_q;

  ets_edge_det #(.SYNC(SYNC)) u_edge (
    .clk_i, .rst_ni, .sig_i,
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  ets_timed_slot #(.TS_W(TS_W), .PW(2)) u_gate_slot (
    .clk_i, .rst_ni, .set_i(gate_set_i), .time_i(gate_time_i),
    .pay_i(gate_mode_i), .now_i(now_q), .fire_o(g_fire), .pay_o(g_pay)
  );

  ets_timed_slot #(.TS_W(TS_W), .PW(1)) u_smp_slot (
    .clk_i, .rst_ni, .set_i(smp_set_i), .time_i(smp_time_i),
    .pay_i(1'b1), .now_i(now_q), .fire_o(s_fire), .pay_o(s_pay)
  );

  // gate change applies within the cycle its time is reached
  assign mode_eff = g_fire ? g_pay : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= GM_OFF;
    else if (g_fire) mode_q <= g_pay;
  end

  assign hit  = (mode_eff[0] & rise) | (mode_eff[1] & fall);
  assign push = (s_fire & s_pay) | hit;
  // sample wins over a coincident edge: one entry, kind=sample
  assign wentry = {now_q, (s_fire & s_pay), lvl};

  ets_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .wdata_i(wentry), .pop_i(rd_req_i),
    .head_o(head), .empty_o(empty), .ovf_o(fifo_ovf), .fill_o(fill_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovf_q <= 1'b0;
    else if (fifo_ovf) ovf_q <= 1'b1;
    else if (rd_req_i) ovf_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_empty_o <= 1'b1;
      rsp_ovf_o   <= 1'b0;
      rsp_gate_o  <= 1'b0;
      rsp_ts_o    <= '0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= rd_req_i;
      if (rd_req_i) begin
        rsp_empty_o <= empty;
        rsp_ovf_o   <= ovf_q;
        rsp_gate_o  <= (mode_eff != GM_OFF);
        rsp_ts_o    <= empty ? '0 : head[EW-1:DATA_W];
        rsp_data_o  <= empty ? '0 : head[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/evt_stamper_chk.sv
module evt_stamper_chk #(
  parameter int unsigned TS_W  = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [TS_W-1:0] now_o,
  input logic            rd_req_i,
  input logic            rsp_valid_o,
  input logic            rsp_empty_o,
  input logic            rsp_ovf_o,
  input logic [CW-1:0]   fill,
  input logic            ovf_q
);
  // R1
  now_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> now_o == TS_W'($past(now_o) + 1'b1));
  // R6
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rsp_valid_o);
  // R6
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rsp_valid_o);
  // R7
  empty_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && fill == '0) |=> rsp_empty_o);
  // R8
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= CW'(DEPTH));
  // R9
  ovf_report_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && ovf_q) |=> rsp_ovf_o);
endmodule

bind evt_stamper evt_stamper_chk #(.TS_W(TS_W), .DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .now_o(now_o), .rd_req_i(rd_req_i),
  .rsp_valid_o(rsp_valid_o), .rsp_empty_o(rsp_empty_o), .rsp_ovf_o(rsp_ovf_o),
  .fill(fill_w), .ovf_q(ovf_q)
);

// File: tb/tb_evt_stamper.sv
`timescale 1ns/1ps
module tb_evt_stamper;
  localparam int TS_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sig = 1'b0, gate_set = 1'b0, smp_set = 1'b0, rd_req = 1'b0;
  logic [1:0] gate_mode = 2'b00;
  logic [TS_W-1:0] gate_time = '0, smp_time = '0;
  logic rsp_valid, rsp_empty, rsp_ovf, rsp_gate;
  logic [TS_W-1:0] rsp_ts, now;
  logic [1:0] rsp_data;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  evt_stamper #(.TS_W(TS_W), .DEPTH(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sig_i(sig),
    .gate_set_i(gate_set), .gate_mode_i(gate_mode), .gate_time_i(gate_time),
    .smp_set_i(smp_set), .smp_time_i(smp_time), .rd_req_i(rd_req),
    .rsp_valid_o(rsp_valid), .rsp_empty_o(rsp_empty), .rsp_ovf_o(rsp_ovf),
    .rsp_gate_o(rsp_gate), .rsp_ts_o(rsp_ts), .rsp_data_o(rsp_data), .now_o(now)
  );

  // {mode[1:0], start_lvl, end_lvl, expect_entry, expect_lvl}
  localparam logic [5:0] VEC [7] = '{
    6'b01_01_1_1, 6'b01_10_0_0, 6'b10_01_0_0, 6'b10_10_1_0,
    6'b11_01_1_1, 6'b11_10_1_0, 6'b00_01_0_0
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_now(input logic [TS_W-1:0] t);
    while (now != t) @(negedge clk);
  endtask

  task automatic gate_cmd(input logic [1:0] m, input logic [TS_W-1:0] t);
    gate_set = 1'b1; gate_mode = m; gate_time = t;
    @(negedge clk);
    gate_set = 1'b0;
  endtask

  task automatic smp_cmd(input logic [TS_W-1:0] t);
    smp_set = 1'b1; smp_time = t;
    @(negedge clk);
    smp_set = 1'b0;
  endtask

  task automatic rd();
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [TS_W-1:0] n0, t, c;
    logic [TS_W-1:0] ns [5];

    // reset checks
    cyc(3);
    chk(rsp_valid == 1'b0, "R2 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    #1;
    chk(now == 0, "R1 now after release", now, 0);
    @(negedge clk);
    n0 = now;
    @(negedge clk);
    chk(now == n0 + 1, "R1 now step", now, n0 + 1);
    chk(rsp_valid == 1'b0, "R2 no rsp without req", rsp_valid, 0);
    rd();
    chk(rsp_valid && rsp_empty, "R2 empty after reset", rsp_empty, 1);
    chk(rsp_ovf == 1'b0, "R2 ovf clear", rsp_ovf, 0);
    chk(rsp_gate == 1'b0, "R2 gate closed", rsp_gate, 0);

    // R3 table of edge/mode cases
    for (int v = 0; v < 7; v++) begin
      sig = VEC[v][3];
      cyc(6);
      gate_cmd(VEC[v][5:4], now + 2);
      cyc(5);
      sig = VEC[v][2];
      n0 = now;
      cyc(6);
      gate_cmd(2'b00, now + 1);
      cyc(4);
      rd();
      chk(rsp_empty == !VEC[v][1], $sformatf("R3 vec%0d entry present", v), !rsp_empty, VEC[v][1]);
      if (VEC[v][1] && !rsp_empty) begin
        chk(rsp_data == {1'b0, VEC[v][0]}, $sformatf("R3 vec%0d data", v), rsp_data, {1'b0, VEC[v][0]});
        chk(rsp_ts == n0 + 2, $sformatf("R3 vec%0d stamp", v), rsp_ts, n0 + 2);
      end
    end

    // R4 window boundaries
    sig = 1'b0;
    cyc(4);
    t = now + 20;
    gate_cmd(2'b11, t);
    wait_now(t - 3); sig = 1'b1;  // stamped t-1: outside
    @(negedge clk);  sig = 1'b0;  // stamped t: inside
    wait_now(t + 2);
    c = t + 15;
    gate_cmd(2'b00, c);
    wait_now(c - 3); sig = 1'b1;  // stamped c-1: inside
    @(negedge clk);  sig = 1'b0;  // stamped c: outside
    cyc(6);
    rd();
    chk(!rsp_empty && rsp_ts == t, "R4 open boundary stamp", rsp_ts, t);
    chk(rsp_data == 2'b00, "R4 open boundary data", rsp_data, 0);
    rd();
    chk(!rsp_empty && rsp_ts == c - 1, "R4 close boundary stamp", rsp_ts, c - 1);
    chk(rsp_data == 2'b01, "R4 close boundary data", rsp_data, 1);
    rd();
    chk(rsp_empty, "R4 nothing outside window", rsp_empty, 1);

    // R5 sample coinciding with an edge, R7 gate marker
    gate_cmd(2'b11, now);
    cyc(2);
    rd();
    chk(rsp_empty && rsp_gate, "R7 empty read shows gate open", rsp_gate, 1);
    t = now + 10;
    smp_cmd(t);
    wait_now(t - 2); sig = 1'b1;
    cyc(6);
    gate_cmd(2'b00, now);
    cyc(2);
    rd();
    chk(!rsp_empty && rsp_ts == t, "R5 sample stamp", rsp_ts, t);
    chk(rsp_data == 2'b11, "R5 sample kind and level", rsp_data, 3);
    rd();
    chk(rsp_empty, "R5 single entry for coincident edge", rsp_empty, 1);

    // R10 replacement of a pending sample (gate closed)
    smp_cmd(now + 10);
    t = now + 20;
    smp_cmd(t);
    wait_now(t + 4);
    rd();
    chk(!rsp_empty && rsp_ts == t, "R10 replaced sample stamp", rsp_ts, t);
    chk(rsp_data == 2'b11, "R5 sample while gate closed", rsp_data, 3);
    rd();
    chk(rsp_empty, "R10 first request dropped", rsp_empty, 1);

    // R8/R9 overflow: five edges into four slots
    gate_cmd(2'b11, now);
    cyc(2);
    for (int i = 0; i < 5; i++) begin
      cyc(4);
      sig = ~sig;
      ns[i] = now;
    end
    cyc(5);
    gate_cmd(2'b00, now);
    cyc(2);
    rd();
    chk(rsp_ovf == 1'b1, "R9 overflow on next read", rsp_ovf, 1);
    chk(rsp_ts == ns[0] + 2, "R8 oldest entry kept", rsp_ts, ns[0] + 2);
    rd();
    chk(rsp_ovf == 1'b0, "R9 cleared by read", rsp_ovf, 0);
    chk(rsp_ts == ns[1] + 2, "R6 order second", rsp_ts, ns[1] + 2);
    rd();
    rd();
    chk(!rsp_empty && rsp_ts == ns[3] + 2, "R8 fourth entry kept", rsp_ts, ns[3] + 2);
    rd();
    chk(rsp_empty, "R8 overflowing event lost", rsp_empty, 1);
    chk(rsp_ovf == 1'b0, "R9 stays clear", rsp_ovf, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule